// File: doc/BRIEF.md
# Five-Row Column Line Buffer

This block sits in front of a 5x5 image kernel. It accepts grayscale pixels in raster order, one per clock at most, through a valid/ready input. For each accepted pixel it presents one column of five vertically adjacent pixels. Rows 0 to 3 of that column are taken from four on-chip line stores: row 0 is the oldest line and row 3 is the line just above. Row 4 is the pixel that has just arrived. All five values leave together as a single transfer on a valid/ready output, so a downstream kernel only has to shift columns into its window.

All four line stores are indexed by one column counter. In the same step that a column is read out, each store takes the value of the store below it, and the bottom store takes the new pixel. The lines therefore roll upward by one row without any address arithmetic. Each frame is `IMG_H-2` scan lines of `IMG_W` pixels. A one-cycle pulse marks the column that ends a frame. The line stores are cleared only at reset and carry their contents into the next frame.

Top module: `line_col_buffer`

## Requirements
- R1: After reset, `out_valid` and `frame_done` are 0, `in_ready` is 1, and all line stores read as zero.
- R2: The column produced for an accepted pixel carries that pixel unchanged on `out_row4`.
- R3: For the k-th pixel accepted since reset (k counting from 0), `out_row3`, `out_row2`, `out_row1` and `out_row0` equal the pixels accepted at k-IMG_W, k-2*IMG_W, k-3*IMG_W and k-4*IMG_W. When that index is negative, the value is 0.
- R4: Each accepted pixel produces exactly one output transfer, in acceptance order. `out_valid` is high in the cycle after the accept. It drops after a transfer unless another pixel was accepted at the same edge.
- R5: `in_ready` equals `!out_valid || out_ready`.
- R6: While `out_valid` is high and `out_ready` is low, no pixel is accepted and the five output rows hold their values.
- R7: A frame is `(IMG_H-2)*IMG_W` accepted pixels. `frame_done` is high for exactly one cycle, the cycle after the last pixel of each frame is accepted, while that pixel's column is on the outputs.
- R8: The line stores keep their contents across frame boundaries. R3 counts pixels continuously over frames.
- R9: With `out_ready` held high, `in_ready` stays high, so one pixel can be taken every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | PIX_W | Input pixel |
| in_ready | output | 1 | Block can take a pixel this cycle |
| out_valid | output | 1 | Column held on the outputs |
| out_ready | input | 1 | Downstream takes the column |
| out_row0 | output | PIX_W | Oldest line |
| out_row1 | output | PIX_W | Third line back |
| out_row2 | output | PIX_W | Second line back |
| out_row3 | output | PIX_W | Line just above |
| out_row4 | output | PIX_W | Incoming pixel |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions take the upstream to be a plain valid/ready source. They also assume that `in_pix` is only sampled at an accept, so nothing is assumed about the pixel when `in_valid` is low. The checks make no assumption that `in_valid` is held under stall. The stimulus runs one stretch at full rate and long stretches with random gaps on both sides. It also holds `out_ready` low while pixels wait, so that stalls begin at every column and row position. It runs several frames, so that the line stores carry across frame boundaries.

// File: rtl/line_col_buffer.sv
module line_col_buffer #(
  parameter int PIX_W = 16,
  parameter int IMG_W = 8,
  parameter int IMG_H = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_row0,
  output logic [PIX_W-1:0] out_row1,
  output logic [PIX_W-1:0] out_row2,
  output logic [PIX_W-1:0] out_row3,
  output logic [PIX_W-1:0] out_row4,
  output logic             frame_done
);
  localparam int LINES = 4;
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int ROW_W = $clog2(IMG_H);

  logic [PIX_W-1:0] line_q [LINES][IMG_W];
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  wire accept  = in_valid & in_ready;
  wire col_end = (col_q == COL_W'(IMG_W-1));
  wire row_end = (row_q == ROW_W'(IMG_H-1));

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= ROW_W'(2);
    end else if (accept) begin
      col_q <= col_end ? '0 : col_q + 1'b1;
      if (col_end)
        row_q <= row_end ? ROW_W'(2) : row_q + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int c = 0; c < IMG_W; c++) line_q[g][c] <= '0;
        end else if (accept) begin
          if (g == LINES-1) line_q[g][col_q] <= in_pix;
          else              line_q[g][col_q] <= line_q[(g+1)%LINES][col_q];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      frame_done <= 1'b0;
      out_row0   <= '0;
      out_row1   <= '0;
      out_row2   <= '0;
      out_row3   <= '0;
      out_row4   <= '0;
    end else begin
      frame_done <= accept & col_end & row_end;
      if (accept) begin
        out_valid <= 1'b1;
        out_row0  <= line_q[0][col_q];
        out_row1  <= line_q[1][col_q];
        out_row2  <= line_q[2][col_q];
        out_row3  <= line_q[3][col_q];
        out_row4  <= in_pix;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/line_col_buffer_chk.sv
module line_col_buffer_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pix,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_row0,
  input logic [PIX_W-1:0] out_row1,
  input logic [PIX_W-1:0] out_row2,
  input logic [PIX_W-1:0] out_row3,
  input logic [PIX_W-1:0] out_row4,
  input logic             frame_done
);
  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_row4 == $past(in_pix)); // R2
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row0) && $stable(out_row1)
      && $stable(out_row2) && $stable(out_row3) && $stable(out_row4)); // R6
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R5
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
  AST_DONE_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid); // R7
endmodule

bind line_col_buffer line_col_buffer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_row0(out_row0), .out_row1(out_row1), .out_row2(out_row2),
  .out_row3(out_row3), .out_row4(out_row4), .frame_done(frame_done)
);

// File: tb/sim_line_col_buffer.sv
module sim_line_col_buffer;
  localparam int PW = 16;
  localparam int W  = 8;
  localparam int H  = 6;
  localparam int FRAME = (H-2)*W;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [PW-1:0] in_pix = '0;
  logic in_ready, out_valid, frame_done;
  logic [PW-1:0] r0, r1, r2, r3, r4;

  always #2 clk = ~clk;

  line_col_buffer #(.PIX_W(PW), .IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_row0(r0), .out_row1(r1), .out_row2(r2), .out_row3(r3), .out_row4(r4),
    .frame_done(frame_done));

  int checks = 0, failures = 0;
  bit done = 0;
  int hist[$];
  logic [5*PW-1:0] expq[$];

  task automatic chk(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  function automatic logic [PW-1:0] back(int m);
    int idx = hist.size() - m*W;
    return (idx >= 0) ? PW'(hist[idx]) : '0;
  endfunction

  initial begin
    bit exp_fd = 0, was_stall = 0;
    logic [5*PW-1:0] held = '0, cur, e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R1", $sformatf("out_valid act=%0b exp=0", out_valid));
    chk(frame_done == 0, "R1", $sformatf("frame_done act=%0b exp=0", frame_done));
    chk(in_ready == 1, "R1", $sformatf("in_ready act=%0b exp=1", in_ready));
    for (int cyc = 0; cyc < 700; cyc++) begin
      @(negedge clk);
      cur = {r0, r1, r2, r3, r4};
      chk(out_valid == (expq.size() != 0), "R4",
          $sformatf("out_valid act=%0b exp=%0b", out_valid, expq.size() != 0));
      chk(frame_done == exp_fd, "R7",
          $sformatf("frame_done act=%0b exp=%0b", frame_done, exp_fd));
      if (was_stall)
        chk(cur == held, "R6", $sformatf("held column act=%h exp=%h", cur, held));
      if (cyc < 100) begin
        in_valid = 1; out_ready = 1;
      end else if (cyc >= 400 && cyc < 430) begin
        in_valid = 1; out_ready = 0;
      end else begin
        in_valid = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
      end
      in_pix = PW'($urandom);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R5",
          $sformatf("in_ready act=%0b exp=%0b", in_ready, !out_valid || out_ready));
      if (out_ready)
        chk(in_ready == 1, "R9", $sformatf("in_ready act=%0b exp=1", in_ready));
      if (out_valid && out_ready && expq.size() != 0) begin
        e = expq.pop_front();
        chk(cur[PW-1:0] == e[PW-1:0], "R2",
            $sformatf("row4 act=%h exp=%h", cur[PW-1:0], e[PW-1:0]));
        chk(cur[5*PW-1:PW] == e[5*PW-1:PW], "R3",
            $sformatf("rows0-3 act=%h exp=%h", cur[5*PW-1:PW], e[5*PW-1:PW]));
      end
      exp_fd = 0;
      if (in_valid && in_ready) begin
        expq.push_back({back(4), back(3), back(2), back(1), in_pix});
        hist.push_back(int'(in_pix));
        if (hist.size() % FRAME == 0) exp_fd = 1;
      end
      was_stall = out_valid && !out_ready;
      held = cur;
    end
    chk(hist.size() > 3*FRAME, "R8",
        $sformatf("pixels accepted act=%0d exp>%0d", hist.size(), 3*FRAME));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule